// File: doc/BRIEF.md
# Palette Colour Table with Sequenced Register Access

This block holds the colour lookup table of a pseudocolour display path. A CPU reaches the table through a small word-wide register port: it first selects an entry number, then transfers the red, green and blue components of that entry one access at a time. After the third component the entry number moves to the next entry by itself, so a whole palette loads as one long stream of component writes.

Besides the 256 normal entries, the table keeps four overlay entries that colour the hardware cursor. They are written through their own register offset and are picked by the two low bits of the current entry number. A second port, used by the pixel pipeline, takes a 9-bit entry number (0 to 255 for pixels, 256 to 259 for overlays) and returns the 24-bit colour one clock later.

Top module: `palette_dac`

## Requirements
- R1: After reset, every component of every entry is zero except entries 255, 256 and 258, which read as 0xFFFFFF; the entry number and the component phase are both zero (red).
- R2: A write at byte offset 0x0 loads the entry number from data bits 31:24 and returns the component phase to red.
- R3: A write at byte offset 0x4 stores data bits 31:24 into the current-phase component of normal entry `index`; phases run red, green, blue, and in a lookup result red is bits 23:16, green bits 15:8, blue bits 7:0.
- R4: Each colour access (write at 0x4 or 0xC, or any read) advances the phase; the access made in the blue phase returns the phase to red and raises the entry number by one, wrapping from 255 to 0.
- R5: A write at byte offset 0xC stores into overlay entry 256 + `index[1:0]` with the same component order and the same sequencing as R3 and R4; the normal entry at `index` is untouched.
- R6: A read (valid with write low) returns the current-phase component of normal entry `index` in bits 31:24 and zero in bits 23:0; `reg_rdata_o` is zero whenever no read is presented.
- R7: A write at any other offset (0x8, or one with nonzero bits 1:0) changes neither the table nor the entry number nor the phase.
- R8: `lut_rgb_o` shows the colour of entry `lut_entry_i` one clock after the entry number is presented, and a register write is visible to a lookup presented in the following cycle.
- R9: A lookup entry number above 259 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_valid_i | input | 1 | Register access strobe, one access per cycle |
| reg_write_i | input | 1 | 1 for write, 0 for read |
| reg_addr_i | input | 4 | Byte offset of the access |
| reg_wdata_i | input | 32 | Write data; component or entry number in bits 31:24 |
| reg_rdata_o | output | 32 | Read data, valid in the cycle of the read |
| lut_entry_i | input | 9 | Entry number for the pixel lookup |
| lut_rgb_o | output | 24 | Registered colour {R,G,B} of the requested entry |

## Verification
The checker watches the sequencing state on every cycle: an entry-number write lands with the phase at red, the phase never leaves its three legal values, the blue-phase access wraps the phase and steps the entry number, ignored offsets leave both untouched, and read data keeps its low 24 bits zero and is zero when idle. Whether the right bytes end up in the right entries, the reset colours, overlay addressing, wrap from 255 to 0 and lookup latency can only be shown by the bench, which programs entries through the register port and reads them back through both ports.

// File: rtl/palette_pkg.sv
package palette_pkg;
  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_e;

  // register byte offsets
  localparam int unsigned OFS_INDEX   = 'h0;
  localparam int unsigned OFS_NORMAL  = 'h4;
  localparam int unsigned OFS_OVERLAY = 'hC;
endpackage

// File: rtl/palette_seq.sv
module palette_seq
  import palette_pkg::*;
#(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned N_OVL  = 4,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned COMP_W = 8,
  localparam int unsigned NORM_N = 1 << IDX_W,
  localparam int unsigned ENT_W  = $clog2(NORM_N + N_OVL),
  localparam int unsigned OVL_W  = $clog2(N_OVL)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [IDX_W-1:0]  idx_o,
  output phase_e            phase_o,
  output logic              wr_en_o,
  output logic [ENT_W-1:0]  wr_entry_o,
  output logic [COMP_W-1:0] wr_comp_o,
  output logic              rd_en_o
);
  logic [IDX_W-1:0] idx_q, idx_d;
  phase_e           phase_q, phase_d;
  logic             load_idx, wr_norm, wr_ovl, step;

  assign load_idx = valid_i && write_i && (addr_i == ADDR_W'(OFS_INDEX));
  assign wr_norm  = valid_i && write_i && (addr_i == ADDR_W'(OFS_NORMAL));
  assign wr_ovl   = valid_i && write_i && (addr_i == ADDR_W'(OFS_OVERLAY));
  assign rd_en_o  = valid_i && !write_i;
  assign step     = wr_norm || wr_ovl || rd_en_o;

  always_comb begin
    idx_d   = idx_q;
    phase_d = phase_q;
    if (load_idx) begin
      idx_d   = wdata_i[DATA_W-1 -: IDX_W];
      phase_d = PH_RED;
    end else if (step) begin
      unique case (phase_q)
        PH_RED:  phase_d = PH_GRN;
        PH_GRN:  phase_d = PH_BLU;
        default: begin
          phase_d = PH_RED;
          idx_d   = idx_q + 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      phase_q <= PH_RED;
    end else begin
      idx_q   <= idx_d;
      phase_q <= phase_d;
    end
  end

  assign idx_o      = idx_q;
  assign phase_o    = phase_q;
  assign wr_en_o    = wr_norm || wr_ovl;
  assign wr_comp_o  = wdata_i[DATA_W-1 -: COMP_W];
  assign wr_entry_o = wr_ovl ? ENT_W'(NORM_N) + ENT_W'(idx_q[OVL_W-1:0])
                             : ENT_W'(idx_q);
endmodule

// File: rtl/palette_store.sv
module palette_store
  import palette_pkg::*;
#(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned N_OVL  = 4,
  parameter int unsigned COMP_W = 8,
  localparam int unsigned NORM_N = 1 << IDX_W,
  localparam int unsigned N_ENT  = NORM_N + N_OVL,
  localparam int unsigned ENT_W  = $clog2(N_ENT),
  localparam int unsigned RGB_W  = 3 * COMP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ENT_W-1:0]  wr_entry_i,
  input  phase_e            wr_phase_i,
  input  logic [COMP_W-1:0] wr_comp_i,
  input  logic [IDX_W-1:0]  cpu_idx_i,
  output logic [RGB_W-1:0]  cpu_rgb_o,
  input  logic [ENT_W-1:0]  lut_entry_i,
  output logic [RGB_W-1:0]  lut_rgb_o
);
  logic [RGB_W-1:0] mem [N_ENT];

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    // last pseudocolour entry, first and third overlay reset to white
    localparam bit WHITE = (e == NORM_N - 1) || (e == NORM_N) || (e == NORM_N + 2);
    localparam logic [RGB_W-1:0] RST_VAL = WHITE ? '1 : '0;
    logic [RGB_W-1:0] ent_q;
    logic             hit;

    assign hit = wr_en_i && (wr_entry_i == ENT_W'(e));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_q <= RST_VAL;
      end else if (hit) begin
        unique case (wr_phase_i)
          PH_RED:  ent_q[2*COMP_W +: COMP_W] <= wr_comp_i;
          PH_GRN:  ent_q[COMP_W +: COMP_W]   <= wr_comp_i;
          default: ent_q[0 +: COMP_W]        <= wr_comp_i;
        endcase
      end
    end

    assign mem[e] = ent_q;
  end

  assign cpu_rgb_o = mem[cpu_idx_i];
  assign lut_rgb_o = (lut_entry_i < ENT_W'(N_ENT)) ? mem[lut_entry_i] : '0;
endmodule

// File: rtl/palette_lookup.sv
module palette_lookup #(
  parameter int unsigned RGB_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [RGB_W-1:0] tbl_rgb_i,
  output logic [RGB_W-1:0] rgb_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rgb_o <= '0;
    else         rgb_o <= tbl_rgb_i;
  end
endmodule

// File: rtl/palette_dac.sv
module palette_dac
  import palette_pkg::*;
#(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned N_OVL  = 4,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned COMP_W = 8,
  localparam int unsigned ENT_W = $clog2((1 << IDX_W) + N_OVL),
  localparam int unsigned RGB_W = 3 * COMP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_valid_i,
  input  logic              reg_write_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [ENT_W-1:0]  lut_entry_i,
  output logic [RGB_W-1:0]  lut_rgb_o
);
  logic [IDX_W-1:0]  idx_q;
  phase_e            phase_q;
  logic              wr_en, rd_en;
  logic [ENT_W-1:0]  wr_entry;
  logic [COMP_W-1:0] wr_comp, rd_comp;
  logic [RGB_W-1:0]  cpu_rgb, tbl_rgb;

  palette_seq #(
    .IDX_W(IDX_W), .N_OVL(N_OVL), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .COMP_W(COMP_W)
  ) u_seq (
    .clk_i, .rst_ni,
    .valid_i   (reg_valid_i),
    .write_i   (reg_write_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .idx_o     (idx_q),
    .phase_o   (phase_q),
    .wr_en_o   (wr_en),
    .wr_entry_o(wr_entry),
    .wr_comp_o (wr_comp),
    .rd_en_o   (rd_en)
  );

  palette_store #(
    .IDX_W(IDX_W), .N_OVL(N_OVL), .COMP_W(COMP_W)
  ) u_store (
    .clk_i, .rst_ni,
    .wr_en_i    (wr_en),
    .wr_entry_i (wr_entry),
    .wr_phase_i (phase_q),
    .wr_comp_i  (wr_comp),
    .cpu_idx_i  (idx_q),
    .cpu_rgb_o  (cpu_rgb),
    .lut_entry_i(lut_entry_i),
    .lut_rgb_o  (tbl_rgb)
  );

  palette_lookup #(.RGB_W(RGB_W)) u_lookup (
    .clk_i, .rst_ni,
    .tbl_rgb_i(tbl_rgb),
    .rgb_o    (lut_rgb_o)
  );

  always_comb begin
    unique case (phase_q)
      PH_RED:  rd_comp = cpu_rgb[2*COMP_W +: COMP_W];
      PH_GRN:  rd_comp = cpu_rgb[COMP_W +: COMP_W];
      default: rd_comp = cpu_rgb[0 +: COMP_W];
    endcase
  end

  assign reg_rdata_o = rd_en ? {rd_comp, {(DATA_W-COMP_W){1'b0}}} : '0;
endmodule

// File: rtl/palette_dac_chk.sv
module palette_dac_chk #(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned COMP_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_valid_i,
  input logic              reg_write_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic [IDX_W-1:0]  idx_q,
  input logic [1:0]        phase_q
);
  logic ofs_idx, ofs_col, colour_acc, rd_acc;
  assign ofs_idx    = reg_addr_i == ADDR_W'('h0);
  assign ofs_col    = (reg_addr_i == ADDR_W'('h4)) || (reg_addr_i == ADDR_W'('hC));
  assign rd_acc     = reg_valid_i && !reg_write_i;
  assign colour_acc = rd_acc || (reg_valid_i && reg_write_i && ofs_col);

  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      rst_state_chk: assert (idx_q == '0 && phase_q == 2'd0);
    end
  end

  // R2
  idx_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_valid_i && reg_write_i && ofs_idx |=>
      idx_q == $past(reg_wdata_i[DATA_W-1 -: IDX_W]) && phase_q == 2'd0);

  // R3
  phase_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q != 2'd3);

  // R4
  blue_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    colour_acc && phase_q == 2'd2 |=>
      phase_q == 2'd0 && idx_q == IDX_W'($past(idx_q) + 1'b1));

  // R4
  phase_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    colour_acc && phase_q != 2'd2 |=>
      phase_q == $past(phase_q) + 2'd1 && $stable(idx_q));

  // R6
  rd_low_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_acc |-> reg_rdata_o[DATA_W-COMP_W-1:0] == '0);

  // R6
  rd_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_acc |-> reg_rdata_o == '0);

  // R7
  ign_ofs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_valid_i && reg_write_i && !ofs_idx && !ofs_col |=>
      $stable(idx_q) && $stable(phase_q));
endmodule

bind palette_dac palette_dac_chk #(
  .IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .COMP_W(COMP_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_valid_i(reg_valid_i),
  .reg_write_i(reg_write_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .reg_rdata_o(reg_rdata_o),
  .idx_q      (idx_q),
  .phase_q    (phase_q)
);

// File: tb/tb_palette_dac.sv
`timescale 1ns/1ps
module tb_palette_dac;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b1;
  logic        reg_valid_i = 1'b0;
  logic        reg_write_i = 1'b0;
  logic [3:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [8:0]  lut_entry_i = '0;
  logic [23:0] lut_rgb_o;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  palette_dac dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .reg_valid_i(reg_valid_i), .reg_write_i(reg_write_i),
    .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o),
    .lut_entry_i(lut_entry_i), .lut_rgb_o(lut_rgb_o)
  );

  // {index, red, green, blue}
  localparam logic [31:0] VEC [5] = '{
    32'h01_20_40_60, 32'h7F_A5_5A_C3, 32'hFE_01_02_03,
    32'h10_FF_00_80, 32'h33_0F_F0_3C
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_valid_i = 1'b1; reg_write_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_valid_i = 1'b0; reg_write_i = 1'b0;
  endtask

  task automatic reg_rd(output logic [31:0] d);
    @(negedge clk);
    reg_valid_i = 1'b1; reg_write_i = 1'b0; reg_addr_i = 4'h4;
    #1 d = reg_rdata_o;
    @(negedge clk);
    reg_valid_i = 1'b0;
  endtask

  task automatic look(input string req, input logic [8:0] e, input logic [23:0] exp);
    @(negedge clk);
    lut_entry_i = e;
    @(posedge clk);
    #1 chk(req, {8'h0, lut_rgb_o}, {8'h0, exp});
  endtask

  task automatic set_idx(input logic [7:0] i);
    reg_wr(4'h0, {i, 24'h0});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    #2 rst_ni = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;

    // R1 reset colours
    look("R1 entry0", 9'd0, 24'h000000);
    look("R1 entry255", 9'd255, 24'hFFFFFF);
    look("R1 entry256", 9'd256, 24'hFFFFFF);
    look("R1 entry257", 9'd257, 24'h000000);
    look("R1 entry258", 9'd258, 24'hFFFFFF);
    look("R1 entry259", 9'd259, 24'h000000);
    // R1 index/phase zero: first read returns red of entry 0
    reg_rd(rd); chk("R1 reset read", rd, 32'h0);
    #1 chk("R6 idle rdata", reg_rdata_o, 32'h0);

    // R3 R8 vector table: program then look up
    for (int i = 0; i < 5; i++) begin
      set_idx(VEC[i][31:24]);
      reg_wr(4'h4, {VEC[i][23:16], 24'h0});
      reg_wr(4'h4, {VEC[i][15:8], 24'h0});
      reg_wr(4'h4, {VEC[i][7:0], 24'h0});
      look("R3 R8 program/lookup", {1'b0, VEC[i][31:24]}, VEC[i][23:0]);
    end
    // R6 read back each vector
    for (int i = 0; i < 5; i++) begin
      set_idx(VEC[i][31:24]);
      reg_rd(rd); chk("R6 read red", rd, {VEC[i][23:16], 24'h0});
      reg_rd(rd); chk("R6 read green", rd, {VEC[i][15:8], 24'h0});
      reg_rd(rd); chk("R6 read blue", rd, {VEC[i][7:0], 24'h0});
    end

    // R4 wrap 255 -> 0 on writes
    set_idx(8'hFF);
    reg_wr(4'h4, 32'hAA00_0000); reg_wr(4'h4, 32'hBB00_0000); reg_wr(4'h4, 32'hCC00_0000);
    reg_wr(4'h4, 32'hDD00_0000); reg_wr(4'h4, 32'hEE00_0000); reg_wr(4'h4, 32'h1100_0000);
    look("R4 entry255", 9'd255, 24'hAABBCC);
    look("R4 wrapped entry0", 9'd0, 24'hDDEE11);
    // R4 R6 reads also advance and wrap
    set_idx(8'hFF);
    reg_rd(rd); reg_rd(rd); reg_rd(rd);
    reg_rd(rd); chk("R4 R6 read after wrap", rd, 32'hDD00_0000);

    // R5 overlay through offset 0xC
    set_idx(8'h06);
    reg_wr(4'hC, 32'h1200_0000); reg_wr(4'hC, 32'h3400_0000); reg_wr(4'hC, 32'h5600_0000);
    look("R5 overlay 258", 9'd258, 24'h123456);
    look("R5 normal entry untouched", 9'd6, 24'h000000);
    reg_wr(4'hC, 32'h7800_0000); reg_wr(4'hC, 32'h9A00_0000); reg_wr(4'hC, 32'hBC00_0000);
    look("R5 overlay 259 after advance", 9'd259, 24'h789ABC);

    // R7 ignored offsets between components
    set_idx(8'h40);
    reg_wr(4'h4, 32'h2100_0000);
    reg_wr(4'h8, 32'hFF00_0000);
    reg_wr(4'h6, 32'hFF00_0000);
    reg_wr(4'h4, 32'h4300_0000);
    reg_wr(4'h4, 32'h6500_0000);
    look("R7 ignored offsets", 9'h040, 24'h214365);
    look("R7 next entry untouched", 9'h041, 24'h000000);

    // R2 index write mid-sequence resets phase
    set_idx(8'h50);
    reg_wr(4'h4, 32'h9900_0000);
    set_idx(8'h50);
    reg_wr(4'h4, 32'h0100_0000); reg_wr(4'h4, 32'h0200_0000); reg_wr(4'h4, 32'h0300_0000);
    look("R2 phase reset", 9'h050, 24'h010203);

    // R9 out of range
    look("R9 entry260", 9'd260, 24'h000000);
    look("R9 entry511", 9'd511, 24'h000000);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule